// File: doc/BRIEF.md
# DDR read burst sequencer

This block is a cycle-level, synthesizable model of the read side of a double-data-rate memory device. A command port takes four operations: no-op, bank activate, read, and mode-register set. Each clock cycle the block drives a strobe and a data bus. A clock cycle has two halves, so the bus appears as a rising-half word lane and a falling-half word lane. Separate output-enable bits stand in for the high-impedance state of the strobe and of the data.

An activate opens one bank and stores that bank's row. A read to an open bank is accepted once enough cycles have passed since the activate. After the CAS latency, the block drives a one-cycle low preamble on the strobe, then the burst at two words per cycle, then a one-cycle low postamble. After the postamble it releases the strobe. The storage is a small array filled with a computed pattern. Each word reads back as `{row ^ 8'hC3, bank, column}`, so the bank, the row and the column can each be seen at the data port. Illegal reads and illegal mode codes raise a one-cycle error pulse and drive nothing.

Top module: `ddr_rd_seq`

## Requirements
- R1: An activate (cmdOp=01) opens bank cmdBank and stores row cmdAddr[7:0] for it. Every word read from that bank reads `{row ^ 8'hC3, bank[1:0], col[5:0]}`, and a later activate replaces the stored row.
- R2: A read (cmdOp=10) is accepted only if its bank is open and at least TRCD edges have passed since that bank's last activate. A read to a closed bank or a read that comes too early is rejected: it raises protoErr for the one cycle after its edge and drives neither the strobe nor the data.
- R3: A mode set (cmdOp=11) takes a length code from cmdAddr[2:0] (1,2,3,4 select bursts of 2,4,8,16), the burst type from cmdAddr[3] (0 sequential, 1 interleaved) and the latency from cmdAddr[6:4] (2 or 3). Any other length or latency code is rejected: protoErr pulses and the mode is left unchanged. After reset the mode is length 4, sequential, latency 3.
- R4: A burst of length BL drives data for exactly BL/2 consecutive cycles, two words per cycle.
- R5: If a read is presented in cycle N, its first data cycle is N+CL. In other words, data starts CL-1 cycles after the first cycle that follows the edge that accepted the read.
- R6: In the cycle before the first data cycle, dqsOe=1, dqsHigh=0 and dqOe=0. This is the preamble.
- R7: In every data cycle, dqsOe=1, dqsHigh=1 and dqOe=1. dqRise carries the even burst beat and dqFall carries the following odd beat.
- R8: In the cycle after the last data cycle, dqOe=0 while dqsOe=1 and dqsHigh=0. This is the postamble. In the cycle after the postamble, dqsOe=0.
- R9: For a sequential burst, the column of beat k is the start column plus k, wrapped within the block of BL columns that contains the start column.
- R10: For an interleaved burst, the column of beat k is the start column with its low log2(BL) bits XORed with k.
- R11: Each burst uses the mode and the start column that were current when its read was accepted. A read presented from its own acceptance until its postamble is rejected as in R2. An activate or a mode set during a burst is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdOp | input | 2 | 00 no-op, 01 activate, 10 read, 11 mode set |
| cmdBank | input | 2 | Bank address for activate and read |
| cmdAddr | input | 8 | Row for activate, start column in [5:0] for read, mode field for mode set |
| dqsOe | output | 1 | Strobe is driven (0 = high impedance) |
| dqsHigh | output | 1 | Strobe level in the rising half of the cycle; it is low in the falling half |
| dqOe | output | 1 | Data lanes are driven |
| dqRise | output | 16 | Word presented at the strobe's rising edge |
| dqFall | output | 16 | Word presented at the strobe's falling edge |
| protoErr | output | 1 | One-cycle pulse after a rejected read or mode set |

## Verification
Command decoding and burst output can happen in the same cycle. A new activate, mode set or read may be sampled while a burst is in its preamble or in its first data beats. The bench provokes this by starting a length-16 burst and then, one cycle at a time, issuing an activate to another bank, a mode set to length 2 and latency 2, and a second read. The scoreboard judges the result. The running burst must keep its length-16, latency-3 timing and its columns. The activate and the mode set must raise no error. The overlapping read must pulse protoErr and add no cycles to the bus. A later read must show the new row and the new mode.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_ACT  = 2'b01,
    OP_READ = 2'b10,
    OP_MRS  = 2'b11
  } ddrOp_t;

  // control -> datapath strobes
  typedef struct packed {
    logic actLatch;  // store row for cmdBank
    logic rdLatch;   // snapshot bank, column and mode, clear beat count
    logic beat;      // a data cycle is on the bus
  } seqStrobe_t;

endpackage

// File: rtl/ddr_rd_ctrl.sv
module ddr_rd_ctrl
  import ddr_rd_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 8,
  parameter int TRCD   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ADDR_W-1:0] cmdAddr,
  output seqStrobe_t        strobe,
  output logic [2:0]        modeBl,
  output logic              modeBt,
  output logic              dqsOe,
  output logic              dqsHigh,
  output logic              dqOe,
  output logic              protoErr
);
  localparam int AGE_W = $clog2(TRCD + 1);
  localparam int T_W   = 5;

  logic [NB-1:0]    bankOpen;
  logic [AGE_W-1:0] actAge [NB];
  logic [2:0]       blCode, blRun;
  logic             btSel;
  logic [1:0]       clSel, clRun;
  logic             busy;
  logic [T_W-1:0]   tick;

  logic isAct, isRead, isMrs, rdOk, mrsOk;
  logic [2:0] newBl, newCl;
  logic [T_W-1:0] pairsRun, preT, firstT, postT;
  logic dataCyc;

  always_comb begin
    isAct  = (cmdOp == OP_ACT);
    isRead = (cmdOp == OP_READ);
    isMrs  = (cmdOp == OP_MRS);
    newBl  = cmdAddr[2:0];
    newCl  = cmdAddr[6:4];
    mrsOk  = (newBl >= 3'd1) && (newBl <= 3'd4) && ((newCl == 3'd2) || (newCl == 3'd3));
    rdOk   = isRead && !busy && bankOpen[cmdBank] && (actAge[cmdBank] >= AGE_W'(TRCD));
    pairsRun = T_W'(1) << (blRun - 3'd1);
    firstT   = T_W'(clRun) - T_W'(1);
    preT     = T_W'(clRun) - T_W'(2);
    postT    = firstT + pairsRun;
    dataCyc  = busy && (tick >= firstT) && (tick < postT);
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankOpen[b] <= 1'b0;
        actAge[b]   <= '0;
      end else if (isAct && (cmdBank == BANK_W'(b))) begin
        bankOpen[b] <= 1'b1;
        actAge[b]   <= AGE_W'(1);
      end else if (actAge[b] < AGE_W'(TRCD)) begin
        actAge[b]   <= actAge[b] + AGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      tick     <= '0;
      blCode   <= 3'd2;
      btSel    <= 1'b0;
      clSel    <= 2'd3;
      blRun    <= 3'd2;
      clRun    <= 2'd3;
      protoErr <= 1'b0;
    end else begin
      protoErr <= (isRead && !rdOk) || (isMrs && !mrsOk);
      if (rdOk) begin
        busy  <= 1'b1;
        tick  <= '0;
        blRun <= blCode;
        clRun <= clSel;
      end else if (busy) begin
        if (tick == postT) busy <= 1'b0;
        else tick <= tick + T_W'(1);
      end
      if (isMrs && mrsOk) begin
        blCode <= newBl;
        btSel  <= cmdAddr[3];
        clSel  <= newCl[1:0];
      end
    end
  end

  always_comb begin
    strobe.actLatch = isAct;
    strobe.rdLatch  = rdOk;
    strobe.beat     = dataCyc;
    modeBl  = blCode;
    modeBt  = btSel;
    dqsOe   = busy && (tick >= preT);
    dqsHigh = dataCyc;
    dqOe    = dataCyc;
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (blCode >= 3'd1) && (blCode <= 3'd4) && (clSel >= 2'd2)); // R3
  AST_DQ_INSIDE_DQS: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> dqsOe); // R7
  AST_PREAMBLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |-> ($past(dqsOe) && !$past(dqsHigh))); // R6
  AST_POSTAMBLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqOe) |-> (dqsOe && !dqsHigh)); // R8
  AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (dqsOe && !dqOe && $past(dqOe)) |=> !dqsOe); // R8
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> !$past(strobe.rdLatch)); // R2
endmodule

// File: rtl/ddr_rd_dpath.sv
module ddr_rd_dpath
  import ddr_rd_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int COL_W  = 6,
  parameter int ROW_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [2:0]        modeBl,
  input  logic              modeBt,
  output logic [DATA_W-1:0] dqRise,
  output logic [DATA_W-1:0] dqFall
);
  localparam int IDX_W = BANK_W + COL_W;
  localparam int DEPTH = NB << COL_W;
  localparam logic [ROW_W-1:0] FILL = ROW_W'('hC3);

  logic [DATA_W-1:0] memArr [DEPTH];
  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign memArr[i] = {FILL, IDX_W'(i)};
  end

  logic [ROW_W-1:0]  rowTab [NB];
  logic [BANK_W-1:0] bankQ;
  logic [COL_W-1:0]  colQ;
  logic [2:0]        blQ;
  logic              btQ;
  logic [2:0]        pairIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NB; b++) rowTab[b] <= '0;
      bankQ   <= '0;
      colQ    <= '0;
      blQ     <= 3'd2;
      btQ     <= 1'b0;
      pairIdx <= '0;
    end else begin
      if (strobe.actLatch) rowTab[cmdBank] <= cmdAddr[ROW_W-1:0];
      if (strobe.rdLatch) begin
        bankQ   <= cmdBank;
        colQ    <= cmdAddr[COL_W-1:0];
        blQ     <= modeBl;
        btQ     <= modeBt;
        pairIdx <= '0;
      end else if (strobe.beat) begin
        pairIdx <= pairIdx + 3'd1;
      end
    end
  end

  function automatic logic [COL_W-1:0] beatCol(input logic [COL_W-1:0] start,
                                               input logic [3:0] off,
                                               input logic [COL_W-1:0] mask,
                                               input logic inter);
    logic [COL_W-1:0] o, lo;
    o  = COL_W'(off);
    lo = inter ? (start ^ o) : (start + o);
    return (start & ~mask) | (lo & mask);
  endfunction

  logic [COL_W-1:0]  mask, colE, colO;
  logic [DATA_W-1:0] rowMix;

  always_comb begin
    mask   = COL_W'((1 << blQ) - 1);
    colE   = beatCol(colQ, {pairIdx, 1'b0}, mask, btQ);
    colO   = beatCol(colQ, {pairIdx, 1'b1}, mask, btQ);
    rowMix = {rowTab[bankQ], IDX_W'(0)};
    dqRise = strobe.beat ? (memArr[{bankQ, colE}] ^ rowMix) : '0;
    dqFall = strobe.beat ? (memArr[{bankQ, colO}] ^ rowMix) : '0;
  end

  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beat |-> ({1'b0, pairIdx} < (4'd1 << (blQ - 3'd1)))); // R4
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.beat) && !$past(strobe.rdLatch) && strobe.beat)
      |-> (pairIdx == $past(pairIdx) + 3'd1)); // R9
endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
  import ddr_rd_pkg::*;
#(
  parameter int NB     = 4,
  parameter int COL_W  = 6,
  parameter int ROW_W  = 8,
  parameter int ADDR_W = 8,
  parameter int TRCD   = 3,
  localparam int BANK_W = $clog2(NB),
  localparam int DATA_W = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              dqsOe,
  output logic              dqsHigh,
  output logic              dqOe,
  output logic [DATA_W-1:0] dqRise,
  output logic [DATA_W-1:0] dqFall,
  output logic              protoErr
);
  seqStrobe_t strobe;
  logic [2:0] modeBl;
  logic       modeBt;

  ddr_rd_ctrl #(.NB(NB), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .TRCD(TRCD)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .strobe(strobe), .modeBl(modeBl), .modeBt(modeBt),
    .dqsOe(dqsOe), .dqsHigh(dqsHigh), .dqOe(dqOe), .protoErr(protoErr)
  );

  ddr_rd_dpath #(.NB(NB), .BANK_W(BANK_W), .COL_W(COL_W), .ROW_W(ROW_W),
                 .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .modeBl(modeBl), .modeBt(modeBt), .dqRise(dqRise), .dqFall(dqFall)
  );
endmodule

// File: tb/test_ddr_rd_seq.sv
module test_ddr_rd_seq;
  localparam int TRCD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [1:0] cmdBank = 2'd0;
  logic [7:0] cmdAddr = 8'd0;
  logic dqsOe, dqsHigh, dqOe, protoErr;
  logic [15:0] dqRise, dqFall;

  ddr_rd_seq #(.TRCD(TRCD)) i_ddr_rd_seq (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .dqsOe(dqsOe), .dqsHigh(dqsHigh), .dqOe(dqOe), .dqRise(dqRise), .dqFall(dqFall),
    .protoErr(protoErr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    bit          drv;
    bit          hi;
    bit          dat;
    logic [15:0] r;
    logic [15:0] f;
    string       req;
  } exp_t;
  exp_t expQ[$];

  int checks = 0, errors = 0;
  bit done = 0;
  int blM = 4, clM = 3;
  bit btM = 0;
  logic [7:0] rowM [4];

  function automatic int expCol(int start, int off, int bl, bit inter);
    int lo;
    lo = inter ? ((start ^ off) & (bl - 1)) : ((start + off) & (bl - 1));
    return (start & ~(bl - 1) & 63) | lo;
  endfunction

  function automatic logic [15:0] expWord(int b, int col);
    return {rowM[b] ^ 8'hC3, 2'(b), 6'(col)};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (expQ.size() > 0 && expQ[0].at == cyc) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (dqsOe !== e.drv || dqsHigh !== e.hi || dqOe !== e.dat ||
            (e.dat && (dqRise !== e.r || dqFall !== e.f))) begin
          errors++;
          $display("FAIL %s cyc %0d: got oe=%b hi=%b dq=%b %h/%h exp oe=%b hi=%b dq=%b %h/%h",
                   e.req, cyc, dqsOe, dqsHigh, dqOe, dqRise, dqFall,
                   e.drv, e.hi, e.dat, e.r, e.f);
        end
      end else if (dqsOe || dqOe) begin
        checks++;
        errors++;
        $display("FAIL R2 cyc %0d: unexpected drive dqsOe=%b dqOe=%b exp 0/0", cyc, dqsOe, dqOe);
      end
    end
  end

  task automatic cmd(input logic [1:0] op, input int b, input logic [7:0] a,
                     input bit expErr, input string req);
    int n;
    cmdOp = op; cmdBank = 2'(b); cmdAddr = a;
    n = cyc;
    if (op == 2'b01 && !expErr) rowM[b] = a;
    if (op == 2'b10 && !expErr) begin
      exp_t e;
      e = '{at: n + clM - 1, drv: 1, hi: 0, dat: 0, r: '0, f: '0, req: "R6 preamble"};
      expQ.push_back(e);
      for (int p = 0; p < blM / 2; p++) begin
        e = '{at: n + clM + p, drv: 1, hi: 1, dat: 1,
              r: expWord(b, expCol(int'(a[5:0]), 2 * p, blM, btM)),
              f: expWord(b, expCol(int'(a[5:0]), 2 * p + 1, blM, btM)),
              req: btM ? "R10 R7 R5 data" : "R9 R7 R5 data"};
        expQ.push_back(e);
      end
      e = '{at: n + clM + blM / 2, drv: 1, hi: 0, dat: 0, r: '0, f: '0, req: "R8 R4 postamble"};
      expQ.push_back(e);
      e = '{at: n + clM + blM / 2 + 1, drv: 0, hi: 0, dat: 0, r: '0, f: '0, req: "R8 release"};
      expQ.push_back(e);
    end
    @(negedge clk);
    cmdOp = 2'b00;
    checks++;
    if (protoErr !== expErr) begin
      errors++;
      $display("FAIL %s: protoErr=%b exp %b", req, protoErr, expErr);
    end
  endtask

  task automatic mrs(input int blc, input bit bt, input int clc, input string req);
    bit ok;
    ok = (blc >= 1 && blc <= 4) && (clc == 2 || clc == 3);
    cmd(2'b11, 0, {1'b0, 3'(clc), bt, 3'(blc)}, !ok, req);
    if (ok) begin
      blM = 1 << blc; btM = bt; clM = clc;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) rowM[b] = 8'h00;
    repeat (3) @(negedge clk);
    checks++;
    if (dqsOe !== 1'b0 || dqOe !== 1'b0 || protoErr !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: dqsOe=%b dqOe=%b protoErr=%b exp 0/0/0", dqsOe, dqOe, protoErr);
    end
    rstN = 1'b1;
    idle(2);

    // R2: closed bank, then too-early read, then on-time read
    cmd(2'b10, 2, 8'd0, 1, "R2 closed bank");
    cmd(2'b01, 1, 8'h5A, 0, "R1 activate");
    idle(TRCD - 2);
    cmd(2'b10, 1, 8'd5, 1, "R2 early read");
    cmd(2'b10, 1, 8'd5, 0, "R2 R9 on-time read BL4 CL3");
    idle(12);

    // R10 interleaved, BL8, CL2
    mrs(3, 1, 2, "R3 set BL8 interleaved CL2");
    cmd(2'b10, 1, 8'd13, 0, "R10 read");
    idle(12);

    // R3 invalid codes leave mode intact
    mrs(7, 0, 3, "R3 bad length code");
    mrs(2, 0, 1, "R3 bad latency code");
    cmd(2'b10, 1, 8'd2, 0, "R3 mode kept");
    idle(12);

    // R1 row replaced by new activate
    cmd(2'b01, 1, 8'h0F, 0, "R1 re-activate");
    idle(TRCD);
    mrs(1, 0, 3, "R3 set BL2 seq CL3");
    cmd(2'b10, 1, 8'd9, 0, "R9 BL2 wrap");
    idle(12);

    // R11 overlap: commands during a BL16 burst
    mrs(4, 0, 3, "R3 set BL16 seq CL3");
    cmd(2'b10, 1, 8'd60, 0, "R4 R9 BL16 wrap");
    cmd(2'b01, 3, 8'h11, 0, "R11 activate in burst");
    mrs(1, 0, 2, "R11 mode set in burst");
    cmd(2'b10, 1, 8'd0, 1, "R11 read in burst");
    idle(14);
    cmd(2'b10, 3, 8'd7, 0, "R11 new mode and row");
    idle(12);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R4 scoreboard left %0d items exp 0", expQ.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule